// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block brings a processor core out of reset. Once reset is released it reads two words from the boot ROM, one at a time. The first word becomes the initial stack pointer and the second becomes the initial program counter. While it does this it also presets the link register to all ones and sets the execution-state flag. When both words are in place it pulses a start strobe, and the core may then begin fetching instructions. After that the block stays idle until reset is asserted again.

The ROM is reached through a request channel and a response channel. The request channel carries a byte address under a valid/ready handshake. The block raises `vec_rd_valid` and keeps it raised, with the address unchanged, until it samples `vec_rd_ready` high on a rising edge. It never has more than one request outstanding. The response channel has no back-pressure. The block takes `vec_rsp_data` on any edge where `vec_rsp_valid` is high while it is waiting for a reply, and it discards response beats that arrive at any other time. Reset is asynchronous and active low. Asserting it at any point, even in the middle of a sequence, sends the block back to the first read.

Top module: `vector_fetch_seq`

## Requirements
- R1: While `rst_n` is low, `init_sp` and `init_pc` read 0, `init_xstate` reads 1 and `core_start` reads 0.
- R2: Each sequence makes exactly two ROM requests. The first is to byte address 0 and the second is to byte address DATA_W/8, which is 4 for 32-bit words.
- R3: `init_sp` takes the data of the response to the address-0 request.
- R4: `init_lr` reads all ones at all times.
- R5: `init_pc` takes the data of the response to the second request with bit 0 forced to 0. `init_xstate` takes bit 0 of that same word.
- R6: `core_start` goes high for exactly one cycle, in the cycle after the program-counter response is accepted. From then on the block issues no more requests and all outputs hold until reset.
- R7: Asserting reset in the middle of a sequence clears the loaded values. After release the sequence restarts at address 0.
- R8: While a request is not accepted, `vec_rd_valid` stays high and `vec_rd_addr` stays stable.
- R9: A `vec_rsp_valid` beat that arrives when no response is awaited changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_rd_valid | output | 1 | ROM read request valid |
| vec_rd_ready | input | 1 | ROM accepts the request |
| vec_rd_addr | output | ADDR_W | ROM byte address |
| vec_rsp_valid | input | 1 | ROM read data valid |
| vec_rsp_data | input | DATA_W | ROM read data |
| init_sp | output | DATA_W | Initial stack pointer |
| init_pc | output | DATA_W | Initial program counter, bit 0 cleared |
| init_lr | output | DATA_W | Initial link register, all ones |
| init_xstate | output | 1 | Execution-state flag |
| core_start | output | 1 | One-cycle start strobe |

## Verification
A controller that enters the wrong state shows up on the request port within one cycle. The symptom is a missing request, a request to the wrong address, or a third request. It also shows up as a start strobe that is absent, arrives early, or lasts more than one cycle. A wrong capture decision shows up as a wrong stack-pointer or program-counter value in the very cycle the strobe is high. A stray response that is wrongly accepted corrupts a value that is already visible at the ports. The sweep varies how long the ROM withholds ready, how long it takes to reply, and bit 0 of the program-counter word. It also injects stray responses and applies reset in the middle of a sequence.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    ST_REQ_SP,
    ST_WAIT_SP,
    ST_REQ_PC,
    ST_WAIT_PC,
    ST_DONE
  } vfs_state_e;
endpackage

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PC_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_sp,
  output logic              cap_pc,
  output logic              start
);
  vfs_state_e state_q, state_d;
  logic       start_q;

  // Request and capture decode
  always_comb begin
    rd_valid = (state_q == ST_REQ_SP) || (state_q == ST_REQ_PC);
    rd_addr  = (state_q == ST_REQ_PC) ? ADDR_W'(PC_ADDR) : '0;
    cap_sp   = (state_q == ST_WAIT_SP) && rsp_valid;
    cap_pc   = (state_q == ST_WAIT_PC) && rsp_valid;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REQ_SP:  if (rd_ready) state_d = ST_WAIT_SP;
      ST_WAIT_SP: if (rsp_valid) state_d = ST_REQ_PC;
      ST_REQ_PC:  if (rd_ready) state_d = ST_WAIT_PC;
      ST_WAIT_PC: if (rsp_valid) state_d = ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_REQ_SP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REQ_SP;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= cap_pc;
    end
  end

  assign start = start_q;
endmodule

// File: rtl/vfs_word_reg.sv
module vfs_word_reg #(
  parameter int W         = 32,
  parameter bit CLEAR_LSB = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] d_fmt;

  generate
    if (CLEAR_LSB) begin : g_even
      assign d_fmt = {d[W-1:1], 1'b0};
    end else begin : g_plain
      assign d_fmt = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d_fmt;
  end
endmodule

// File: rtl/vector_fetch_seq.sv
module vector_fetch_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              vec_rd_valid,
  input  logic              vec_rd_ready,
  output logic [ADDR_W-1:0] vec_rd_addr,
  input  logic              vec_rsp_valid,
  input  logic [DATA_W-1:0] vec_rsp_data,
  output logic [DATA_W-1:0] init_sp,
  output logic [DATA_W-1:0] init_pc,
  output logic [DATA_W-1:0] init_lr,
  output logic              init_xstate,
  output logic              core_start
);
  localparam int PC_ADDR = DATA_W / 8;

  logic cap_sp, cap_pc;
  logic xstate_q;

  vfs_ctrl #(.ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ready  (vec_rd_ready),
    .rsp_valid (vec_rsp_valid),
    .rd_valid  (vec_rd_valid),
    .rd_addr   (vec_rd_addr),
    .cap_sp    (cap_sp),
    .cap_pc    (cap_pc),
    .start     (core_start)
  );

  vfs_word_reg #(.W(DATA_W), .CLEAR_LSB(1'b0)) u_sp (
    .clk (clk), .rst_n (rst_n), .load (cap_sp), .d (vec_rsp_data), .q (init_sp)
  );

  vfs_word_reg #(.W(DATA_W), .CLEAR_LSB(1'b1)) u_pc (
    .clk (clk), .rst_n (rst_n), .load (cap_pc), .d (vec_rsp_data), .q (init_pc)
  );

  // Execution-state flag: set by reset, then follows bit 0 of the PC word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      xstate_q <= 1'b1;
    else if (cap_pc) xstate_q <= vec_rsp_data[0];
  end

  assign init_xstate = xstate_q;
  assign init_lr     = '1;
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_rd_valid,
  input logic              vec_rd_ready,
  input logic [ADDR_W-1:0] vec_rd_addr,
  input logic [DATA_W-1:0] init_pc,
  input logic [DATA_W-1:0] init_sp,
  input logic              core_start
);
  localparam int PC_ADDR = DATA_W / 8;

  logic [1:0] acc_n;
  logic       acc;
  assign acc = vec_rd_valid && vec_rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_n <= '0;
    else if (acc && acc_n != 2'd3) acc_n <= acc_n + 2'd1;
  end

  AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_n == 2'd0 |-> vec_rd_addr == '0); // R2
  AST_SECOND_ADDR_PC: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_n == 2'd1 |-> vec_rd_addr == ADDR_W'(PC_ADDR)); // R2
  AST_NO_THIRD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_n == 2'd2 |-> !vec_rd_valid); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd_valid && !vec_rd_ready |=> vec_rd_valid && $stable(vec_rd_addr)); // R8
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    init_pc[0] == 1'b0); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start); // R6
  AST_START_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> acc_n == 2'd2 && !vec_rd_valid); // R6
  AST_HOLD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> $stable(init_pc) && $stable(init_sp)); // R6
endmodule

bind vector_fetch_seq vfs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vfs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vec_rd_valid (vec_rd_valid),
  .vec_rd_ready (vec_rd_ready),
  .vec_rd_addr  (vec_rd_addr),
  .init_pc      (init_pc),
  .init_sp      (init_sp),
  .core_start   (core_start)
);

// File: tb/tb_vector_fetch_seq.sv
`timescale 1ns/1ps
module tb_vector_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [31:0] sp, pc, lr;
  logic        xstate, start;

  int checks = 0, errors = 0;
  int rdy_delay = 0, rsp_lat = 0;
  logic [31:0] sp_word, pc_word;
  bit  inject = 0;

  // bench monitor state
  logic       hs_seen = 0;
  logic [7:0] hs_a = '0, hs_prev = '0, hs_last = '0;
  int         hs_count = 0, start_count = 0;
  // ROM model state
  bit pending = 0;
  int pend_cnt = 0, wait_cnt = 0;
  logic [7:0] pend_addr = '0;

  always #2 clk = ~clk;

  vector_fetch_seq dut (
    .clk (clk), .rst_n (rst_n),
    .vec_rd_valid (rd_valid), .vec_rd_ready (rd_ready), .vec_rd_addr (rd_addr),
    .vec_rsp_valid (rsp_valid), .vec_rsp_data (rsp_data),
    .init_sp (sp), .init_pc (pc), .init_lr (lr),
    .init_xstate (xstate), .core_start (start)
  );

  always @(posedge clk) begin
    hs_seen <= rst_n && rd_valid && rd_ready;
    hs_a    <= rd_addr;
    if (rst_n && rd_valid && rd_ready) begin
      hs_prev  <= hs_last;
      hs_last  <= rd_addr;
      hs_count <= hs_count + 1;
    end
    if (rst_n && start) start_count <= start_count + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      pending = 0; wait_cnt = 0; rd_ready = 0; rsp_valid = 0;
    end else begin
      rsp_valid = 0;
      if (hs_seen) begin pending = 1; pend_cnt = rsp_lat; pend_addr = hs_a; end
      if (pending) begin
        if (pend_cnt == 0) begin
          rsp_valid = 1;
          rsp_data  = (pend_addr == 8'd0) ? sp_word :
                      (pend_addr == 8'd4) ? pc_word : 32'hDEAD_BEEF;
          pending   = 0;
        end else pend_cnt--;
      end
      if (inject) begin rsp_valid = 1; rsp_data = 32'hBAD0_0001; end
      if (rd_valid) begin rd_ready = (wait_cnt >= rdy_delay); wait_cnt++; end
      else begin rd_ready = 0; wait_cnt = 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_words(input int seed, input bit lsb);
    sp_word = 32'h2000_0000 | (32'(seed) << 4);
    pc_word = 32'h0000_1000 + 32'(seed) * 8 + 32'(lsb);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(negedge clk);
    chk(sp == 0, "R1 sp", sp, 0);
    chk(pc == 0, "R1 pc", pc, 0);
    chk(xstate == 1'b1, "R1 xstate", 32'(xstate), 1);
    chk(start == 1'b0, "R1 start", 32'(start), 0);
    chk(lr == 32'hFFFF_FFFF, "R4 lr in reset", lr, 32'hFFFF_FFFF);
  endtask

  task automatic release_reset();
    @(posedge clk); #1 rst_n = 1;
  endtask

  // wait for the strobe, then check every loaded value
  task automatic finish_check(input int hs0, input int st0);
    bit seen = 0;
    for (int i = 0; i < 80 && !seen; i++) begin
      @(negedge clk);
      if (start) seen = 1;
    end
    chk(seen, "R6 start seen", 32'(seen), 1);
    chk(sp == sp_word, "R3 sp", sp, sp_word);
    chk(pc == {pc_word[31:1], 1'b0}, "R5 pc", pc, {pc_word[31:1], 1'b0});
    chk(xstate == pc_word[0], "R5 xstate", 32'(xstate), 32'(pc_word[0]));
    chk(lr == 32'hFFFF_FFFF, "R4 lr", lr, 32'hFFFF_FFFF);
    chk(hs_count - hs0 == 2, "R2 request count", 32'(hs_count - hs0), 2);
    chk(hs_prev == 8'd0, "R2 first addr", 32'(hs_prev), 0);
    chk(hs_last == 8'd4, "R2 second addr", 32'(hs_last), 4);
    repeat (5) @(negedge clk);
    chk(start_count - st0 == 1, "R6 single pulse", 32'(start_count - st0), 1);
    chk(rd_valid == 1'b0, "R6 no request after start", 32'(rd_valid), 0);
    chk(hs_count - hs0 == 2, "R6 no extra request", 32'(hs_count - hs0), 2);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hs0, st0;
    // sweep handshake timing and the PC low bit (R2 R3 R5 R6 R8)
    for (int rd = 0; rd < 3; rd++)
      for (int lat = 0; lat < 3; lat++)
        for (int lsb = 0; lsb < 2; lsb++) begin
          rdy_delay = rd; rsp_lat = lat;
          set_words(rd * 6 + lat * 2 + lsb + 1, lsb[0]);
          do_reset();
          hs0 = hs_count; st0 = start_count;
          release_reset();
          finish_check(hs0, st0);
        end

    // R9: stray response before any request is accepted, and after start
    rdy_delay = 3; rsp_lat = 1;
    set_words(40, 1'b1);
    do_reset();
    hs0 = hs_count; st0 = start_count;
    release_reset();
    inject = 1; @(posedge clk); #1 inject = 0;
    finish_check(hs0, st0);
    @(posedge clk); #1 inject = 1; @(posedge clk); #1 inject = 0;
    repeat (2) @(negedge clk);
    chk(sp == sp_word, "R9 sp after stray beat", sp, sp_word);
    chk(pc == {pc_word[31:1], 1'b0}, "R9 pc after stray beat", pc, {pc_word[31:1], 1'b0});
    chk(start == 1'b0, "R9 no start from stray beat", 32'(start), 0);

    // R7: reset after the stack pointer is loaded, then a fresh sequence
    rdy_delay = 0; rsp_lat = 2;
    set_words(50, 1'b0);
    do_reset();
    hs0 = hs_count;
    release_reset();
    repeat (6) @(negedge clk);
    chk(sp == sp_word, "R7 sp loaded before abort", sp, sp_word);
    chk(start == 1'b0, "R7 no start yet", 32'(start), 0);
    do_reset();
    chk(sp == 0, "R7 sp cleared by reset", sp, 0);
    set_words(60, 1'b1);
    hs0 = hs_count; st0 = start_count;
    release_reset();
    finish_check(hs0, st0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule